// File: doc/BRIEF.md
# NRZI Symbol Serializer/Deserializer with Loopback

This block is the digital datapath of a fiber physical layer that exchanges 5-bit code groups with the layer above it. Everything runs on one bit clock. The block divides that clock by five to make a transmit symbol clock and a receive symbol clock, and it drives both out to the upper layer.

On transmit, the block takes a 5-bit symbol on each rising edge of the transmit symbol clock and sends it out one bit per bit clock, most significant bit first. It converts the stream to NRZI on the way out: a 1 toggles the line and a 0 leaves it unchanged. On receive, it takes a line level that has already been recovered and sampled in the bit-clock domain. It decodes that level back to NRZ and packs each group of five bits into a parallel symbol. The symbol changes on the falling edge of the receive symbol clock, so a consumer can sample it on the rising edge.

An active-low loopback input sends the block's own transmit line into the receive path instead of the line input. An active-low power-down input stops the block. A qualifier filters the raw line-activity flag into a clean signal-detect output. The analog front end, clock recovery and code-group alignment sit outside this block.

Top module: `nrzi_symbol_serdes`

## Requirements
- R1: Both symbol clocks have a period of SYM_W bit clocks. `tx_sym_clk` is high for phases 0 to 2 and low for phases 3 and 4. `rx_sym_clk` is high for phases 4, 0 and 1 and low for phases 2 and 3. Phase 0 is the first bit clock after `tx_sym_clk` rises.
- R2: `tx_sym` is captured on the bit-clock edge where `tx_sym_clk` rises. Its bits are sent bit 4 first. The line is NRZI coded: during the k-th bit period after the capture (k = 1..5), `tx_line` equals its level in the period just before, XOR bit 5−k.
- R3: The receive path decodes NRZI by XOR-ing each sampled line level with the previous one. The first bit of each group of five goes to bit 4 of `rx_sym`. A constant line gives an all-zero symbol. While the block is enabled, `rx_sym` changes only on the edge where `rx_sym_clk` falls.
- R4: When `loop_n` is 0, the receive path takes the block's own transmit line and ignores `rx_line`. A symbol captured on a rising edge of `tx_sym_clk` appears unchanged on `rx_sym` SYM_W+2 bit clocks later, at the falling edge of `rx_sym_clk`.
- R5: When `loop_n` is 1, the receive path takes `rx_line`. If `rx_line` carries `tx_line`, the same symbol appears with the same latency as in R4.
- R6: `sig_det` rises only after `act_raw` has been sampled high on more than QUAL_CYCLES consecutive bit clocks. The default is 625 cycles, which is 5 µs at 125 MHz.
- R7: `sig_det` falls only after `act_raw` has been sampled low on more than QUAL_CYCLES consecutive bit clocks.
- R8: A single sample of `act_raw` that matches the current `sig_det` restarts the count.
- R9: When `run_en` is 0, the outputs change on the next edge: `rx_sym` is forced to 0, `sig_det` is cleared, `tx_line` holds its level and the symbol clocks stop. When `run_en` returns to 1, loopback transfer resumes as in R4.
- R10: During reset, `tx_line` is 0, `rx_sym` is 0, `sig_det` is 0, and both symbol clocks are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock (five times the symbol rate) |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | 1 enables the block, 0 powers it down |
| loop_n | input | 1 | 0 selects loopback, 1 selects normal operation |
| tx_sym | input | SYM_W | Transmit symbol, captured when tx_sym_clk rises |
| tx_sym_clk | output | 1 | Transmit symbol clock |
| tx_line | output | 1 | NRZI serial transmit line |
| rx_line | input | 1 | Recovered NRZI line level, sampled in the bit-clock domain |
| rx_sym | output | SYM_W | Received symbol |
| rx_sym_clk | output | 1 | Receive symbol clock; rx_sym changes on its falling edge |
| act_raw | input | 1 | Raw line-activity flag (line level above threshold) |
| sig_det | output | 1 | Qualified signal detect |

## Verification
The assertions assume that `act_raw`, `rx_line`, `run_en` and `loop_n` are already synchronous to the bit clock. They also assume that `tx_sym` is stable across the capture edge. They do not check anything on entry to power-down, where `rx_sym` clears at any phase. The bench drives every input on the falling edge of the bit clock. It changes `tx_sym` only in phase 3, which is well clear of the capture edge. It switches the receive source or power state only between streams, and it empties its expected-symbol queue each time it does so.

// File: rtl/nrzi_serdes_pkg.sv
`timescale 1ns/1ps
// Shared constants and helpers for the NRZI symbol serdes.
// Assumes symbol widths of four bits or more.
package nrzi_serdes_pkg;

    localparam int unsigned SYM_W_DEFAULT = 5;
    localparam int unsigned QUAL_DEFAULT  = 625;

    // Number of phases in a symbol period during which a symbol clock is high.
    function automatic int unsigned clk_hi_phases(input int unsigned sym_w);
        return (sym_w + 1) / 2;
    endfunction

endpackage

// File: rtl/nrzi_sym_timing.sv
`timescale 1ns/1ps
// Symbol phase counter. Divides the bit clock by SYM_W, makes both symbol
// clocks, and gives the transmit-load and receive-load strobes.
// Assumes: en is synchronous; the phase is held at 0 while disabled.
module nrzi_sym_timing
    import nrzi_serdes_pkg::*;
#(
    parameter int unsigned SYM_W = SYM_W_DEFAULT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tx_load,
    output logic rx_load,
    output logic tx_clk,
    output logic rx_clk
);
    localparam int unsigned PH_W = $clog2(SYM_W);
    localparam int unsigned HI   = clk_hi_phases(SYM_W);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(SYM_W - 1);
    localparam logic [PH_W-1:0] PH_RX   = PH_W'(1);

    logic [PH_W-1:0] ph_q;

    // Advance the phase modulo SYM_W, or park it at 0 while powered down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else if (!en) begin
            ph_q <= '0;
        end else if (ph_q == PH_LAST) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_q + PH_W'(1);
        end
    end

    assign tx_load = en && (ph_q == PH_LAST);
    assign rx_load = en && (ph_q == PH_RX);
    assign tx_clk  = (ph_q < PH_W'(HI));
    assign rx_clk  = (((32'(ph_q) + SYM_W + HI - 2) % SYM_W) < HI);

endmodule

// File: rtl/nrzi_tx_serializer.sv
`timescale 1ns/1ps
// Transmit path. Loads a symbol, shifts it out MSB first and NRZI-encodes
// the result onto a registered line.
// Assumes: load comes once per symbol period; in power-down the line holds.
module nrzi_tx_serializer #(
    parameter int unsigned SYM_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             load,
    input  logic [SYM_W-1:0] sym_in,
    output logic             line_out
);
    logic [SYM_W-1:0] sh_q;
    logic             line_q;

    // Load a new symbol or shift the current one toward the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= sym_in;
        end else begin
            sh_q <= {sh_q[SYM_W-2:0], 1'b0};
        end
    end

    // NRZI encoder: a 1 toggles the line, a 0 holds it; frozen while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= 1'b0;
        end else if (en) begin
            line_q <= line_q ^ sh_q[SYM_W-1];
        end
    end

    assign line_out = line_q;

endmodule

// File: rtl/nrzi_rx_deserializer.sv
`timescale 1ns/1ps
// Receive path. Samples the line, decodes NRZI against the previous level,
// and packs groups of SYM_W bits so the first bit lands in the MSB.
// Assumes: line_in is synchronous to clk; load marks the last bit of a group.
module nrzi_rx_deserializer #(
    parameter int unsigned SYM_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             load,
    input  logic             line_in,
    output logic [SYM_W-1:0] sym_out
);
    logic             lvl_q;
    logic             hist_q;
    logic [SYM_W-2:0] acc_q;
    logic [SYM_W-1:0] sym_q;
    logic             nrz_bit;

    assign nrz_bit = lvl_q ^ hist_q;

    // Keep the current and previous line samples for NRZI decoding.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            lvl_q  <= 1'b0;
            hist_q <= 1'b0;
        end else begin
            lvl_q  <= line_in;
            hist_q <= lvl_q;
        end
    end

    // Gather decoded bits; on load, publish the finished group.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            acc_q <= '0;
            sym_q <= '0;
        end else begin
            acc_q <= {acc_q[SYM_W-3:0], nrz_bit};
            if (load) begin
                sym_q <= {acc_q, nrz_bit};
            end
        end
    end

    assign sym_out = sym_q;

endmodule

// File: rtl/nrzi_sig_qualifier.sv
`timescale 1ns/1ps
// Signal-detect qualifier. The output flips only after the raw flag has
// disagreed with it on more than QUAL_CYCLES consecutive samples.
// Assumes: raw is synchronous; disabled means the output is cleared.
module nrzi_sig_qualifier #(
    parameter int unsigned QUAL_CYCLES = 625
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic raw,
    output logic det
);
    localparam int unsigned CNT_W = $clog2(QUAL_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(QUAL_CYCLES);

    logic [CNT_W-1:0] cnt_q;
    logic             det_q;

    // Count the run of disagreeing samples and flip the output when the run is long enough.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
            det_q <= 1'b0;
        end else if (raw == det_q) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_LIM) begin
            cnt_q <= '0;
            det_q <= raw;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign det = det_q;

endmodule

// File: rtl/nrzi_symbol_serdes.sv
`timescale 1ns/1ps
// Top level of the NRZI symbol serdes. Connects the phase timing, the
// transmit serializer, the receive deserializer, the loopback selector
// and the signal-detect qualifier.
// Assumes: every input is synchronous to bit_clk; rx_line is already recovered.
module nrzi_symbol_serdes
    import nrzi_serdes_pkg::*;
#(
    parameter int unsigned SYM_W       = SYM_W_DEFAULT,
    parameter int unsigned QUAL_CYCLES = QUAL_DEFAULT
) (
    input  logic             bit_clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             loop_n,
    input  logic [SYM_W-1:0] tx_sym,
    output logic             tx_sym_clk,
    output logic             tx_line,
    input  logic             rx_line,
    output logic [SYM_W-1:0] rx_sym,
    output logic             rx_sym_clk,
    input  logic             act_raw,
    output logic             sig_det
);
    logic tx_load;
    logic rx_load;
    logic tx_line_w;
    logic rx_src;

    nrzi_sym_timing #(.SYM_W(SYM_W)) u_timing (
        .clk     (bit_clk),
        .rst_n   (rst_n),
        .en      (run_en),
        .tx_load (tx_load),
        .rx_load (rx_load),
        .tx_clk  (tx_sym_clk),
        .rx_clk  (rx_sym_clk)
    );

    nrzi_tx_serializer #(.SYM_W(SYM_W)) u_tx (
        .clk      (bit_clk),
        .rst_n    (rst_n),
        .en       (run_en),
        .load     (tx_load),
        .sym_in   (tx_sym),
        .line_out (tx_line_w)
    );

    // Loopback selector: an active-low control replaces the line input.
    assign rx_src  = loop_n ? rx_line : tx_line_w;
    assign tx_line = tx_line_w;

    nrzi_rx_deserializer #(.SYM_W(SYM_W)) u_rx (
        .clk     (bit_clk),
        .rst_n   (rst_n),
        .en      (run_en),
        .load    (rx_load),
        .line_in (rx_src),
        .sym_out (rx_sym)
    );

    nrzi_sig_qualifier #(.QUAL_CYCLES(QUAL_CYCLES)) u_sd (
        .clk   (bit_clk),
        .rst_n (rst_n),
        .en    (run_en),
        .raw   (act_raw),
        .det   (sig_det)
    );

endmodule

// File: rtl/nrzi_serdes_checker.sv
`timescale 1ns/1ps
// Assertion checker for nrzi_symbol_serdes, attached with bind.
// Counts runs of act_raw to check the signal-detect timing and watches
// receive output timing and power-down behaviour.
module nrzi_serdes_checker #(
    parameter int unsigned SYM_W       = 5,
    parameter int unsigned QUAL_CYCLES = 625
) (
    input logic             bit_clk,
    input logic             rst_n,
    input logic             run_en,
    input logic             act_raw,
    input logic             tx_line,
    input logic [SYM_W-1:0] rx_sym,
    input logic             rx_sym_clk,
    input logic             sig_det
);
    localparam int unsigned RUN_W = $clog2(QUAL_CYCLES + 2);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(QUAL_CYCLES + 1);

    logic [RUN_W-1:0] hi_run;
    logic [RUN_W-1:0] lo_run;

    // Saturating counts of consecutive high and low samples of act_raw.
    always_ff @(posedge bit_clk) begin
        if (!rst_n) begin
            hi_run <= '0;
            lo_run <= '0;
        end else begin
            hi_run <= !act_raw ? '0 : (hi_run == RUN_MAX ? RUN_MAX : hi_run + RUN_W'(1));
            lo_run <=  act_raw ? '0 : (lo_run == RUN_MAX ? RUN_MAX : lo_run + RUN_W'(1));
        end
    end

    assert_rx_launch_R3: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (!$stable(rx_sym) && $past(run_en)) |-> $fell(rx_sym_clk));

    assert_pd_quiet_R9: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !run_en |=> (rx_sym == '0 && !sig_det && $stable(tx_line)));

    assert_sd_rise_R6: assert property (@(posedge bit_clk) disable iff (!rst_n)
        $rose(sig_det) |-> (hi_run > RUN_W'(QUAL_CYCLES)));

    assert_sd_fall_R7: assert property (@(posedge bit_clk) disable iff (!rst_n)
        ($fell(sig_det) && $past(run_en)) |-> (lo_run > RUN_W'(QUAL_CYCLES)));

endmodule

bind nrzi_symbol_serdes nrzi_serdes_checker #(
    .SYM_W       (SYM_W),
    .QUAL_CYCLES (QUAL_CYCLES)
) u_chk (
    .bit_clk    (bit_clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .act_raw    (act_raw),
    .tx_line    (tx_line),
    .rx_sym     (rx_sym),
    .rx_sym_clk (rx_sym_clk),
    .sig_det    (sig_det)
);

// File: tb/nrzi_symbol_serdes_tb.sv
`timescale 1ns/1ps
module nrzi_symbol_serdes_tb;
    localparam int CLK_PERIOD = 8;
    localparam int SYM_W      = 5;
    localparam int QUAL       = 625;

    logic             bit_clk = 1'b0;
    logic             rst_n, run_en, loop_n, act_raw;
    logic [SYM_W-1:0] tx_sym;
    logic             tx_sym_clk, tx_line, rx_line, rx_sym_clk, sig_det;
    logic [SYM_W-1:0] rx_sym;

    logic ext_loop, rx_force, noise_on, mon_on, watch_on, done;
    int   n_run = 0;
    int   n_fail = 0;
    string mon_tag = "R4";
    logic [SYM_W-1:0] exp_q[$];
    logic [SYM_W-1:0] mon_exp;
    logic             mon_prev_clk = 1'b1;
    logic [SYM_W-1:0] mon_prev_sym = '0;

    always #(CLK_PERIOD/2) bit_clk = ~bit_clk;

    assign rx_line = ext_loop ? tx_line : rx_force;

    nrzi_symbol_serdes #(.SYM_W(SYM_W), .QUAL_CYCLES(QUAL)) u_dut (
        .bit_clk(bit_clk), .rst_n(rst_n), .run_en(run_en), .loop_n(loop_n),
        .tx_sym(tx_sym), .tx_sym_clk(tx_sym_clk), .tx_line(tx_line),
        .rx_line(rx_line), .rx_sym(rx_sym), .rx_sym_clk(rx_sym_clk),
        .act_raw(act_raw), .sig_det(sig_det)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    // Wait for the falling edge of the bit clock that starts phase 3.
    task automatic wait_ph3();
        logic p;
        do begin
            p = tx_sym_clk;
            @(negedge bit_clk);
        end while (!(p && !tx_sym_clk));
    endtask

    // Wait for the falling edge of the bit clock that starts phase 0.
    task automatic wait_ph0();
        logic p;
        do begin
            p = tx_sym_clk;
            @(negedge bit_clk);
        end while (!(!p && tx_sym_clk));
    endtask

    // Driver: present one symbol for the next capture edge and push it to the scoreboard.
    task automatic drive_sym(input logic [SYM_W-1:0] s);
        wait_ph3();
        tx_sym = s;
        exp_q.push_back(s);
    endtask

    task automatic stream(input int n, input int mul, input int add);
        for (int i = 0; i < n; i++) drive_sym(SYM_W'((i * mul + add) % 32));
    endtask

    // R2: follow the NRZI line bit by bit for one symbol.
    task automatic watch_tx(input logic [SYM_W-1:0] s);
        logic lvl;
        wait_ph3();
        tx_sym = s;
        @(negedge bit_clk);
        @(negedge bit_clk);
        lvl = tx_line;
        for (int k = 0; k < SYM_W; k++) begin
            @(negedge bit_clk);
            lvl = lvl ^ s[SYM_W-1-k];
            check(tx_line == lvl, "R2 nrzi line", int'(tx_line), int'(lvl));
        end
    endtask

    // Scoreboard monitor and receive-launch timing check.
    always @(negedge bit_clk) begin
        if (mon_on && rx_sym_clk && !mon_prev_clk && exp_q.size() >= 3) begin
            mon_exp = exp_q.pop_front();
            check(rx_sym == mon_exp, mon_tag, int'(rx_sym), int'(mon_exp));
        end
        if (watch_on && rx_sym != mon_prev_sym)
            check(mon_prev_clk && !rx_sym_clk, "R3 launch edge", int'(rx_sym_clk), 0);
        mon_prev_clk = rx_sym_clk;
        mon_prev_sym = rx_sym;
    end

    always @(negedge bit_clk) if (noise_on) rx_force <= ~rx_force;

    initial begin
        done = 1'b0;
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            summary();
            $finish;
        end
    end

    initial begin
        logic held, hclk;
        logic [SYM_W-1:0] tx_pat, rx_pat;
        rst_n = 0; run_en = 1; loop_n = 1; tx_sym = '0; act_raw = 0;
        ext_loop = 0; rx_force = 0; noise_on = 0; mon_on = 0; watch_on = 0;
        repeat (3) @(negedge bit_clk);
        // R10 reset state
        check(tx_line == 0, "R10 tx_line", int'(tx_line), 0);
        check(rx_sym == 0, "R10 rx_sym", int'(rx_sym), 0);
        check(sig_det == 0, "R10 sig_det", int'(sig_det), 0);
        check(tx_sym_clk == 1, "R10 tx_sym_clk", int'(tx_sym_clk), 1);
        check(rx_sym_clk == 1, "R10 rx_sym_clk", int'(rx_sym_clk), 1);
        rst_n = 1;
        @(negedge bit_clk);
        watch_on = 1;

        // R1 symbol clock shapes, sampled from phase 0
        wait_ph0();
        for (int k = 0; k < SYM_W; k++) begin
            tx_pat[SYM_W-1-k] = tx_sym_clk;
            rx_pat[SYM_W-1-k] = rx_sym_clk;
            if (k < SYM_W - 1) @(negedge bit_clk);
        end
        check(tx_pat == 5'b11100, "R1 tx clock", int'(tx_pat), 28);
        check(rx_pat == 5'b11001, "R1 rx clock", int'(rx_pat), 25);

        // R2 transmit order and NRZI coding
        watch_tx(5'b10110);
        watch_tx(5'b11111);
        watch_tx(5'b00001);
        watch_tx(5'b01000);

        // R3 constant line in normal mode decodes to zero
        tx_sym = 5'b11111;
        repeat (4) wait_ph3();
        @(negedge bit_clk);
        check(rx_sym == 0, "R3 idle line", int'(rx_sym), 0);

        // R4 loopback, rx_line toggling must be ignored
        loop_n = 0; noise_on = 1; exp_q.delete(); mon_tag = "R4 loopback"; mon_on = 1;
        stream(40, 7, 3);
        mon_on = 0; noise_on = 0;

        // R5 normal mode with the line looped outside the block
        loop_n = 1; ext_loop = 1; exp_q.delete(); mon_tag = "R5 line input"; mon_on = 1;
        stream(40, 11, 5);
        mon_on = 0; ext_loop = 0;

        // R6 assertion after more than QUAL high samples
        act_raw = 1;
        repeat (QUAL) @(negedge bit_clk);
        check(sig_det == 0, "R6 before limit", int'(sig_det), 0);
        @(negedge bit_clk);
        check(sig_det == 1, "R6 at limit", int'(sig_det), 1);

        // R8 a matching sample restarts the deassert count
        act_raw = 0;
        repeat (600) @(negedge bit_clk);
        act_raw = 1;
        @(negedge bit_clk);
        act_raw = 0;
        repeat (QUAL) @(negedge bit_clk);
        check(sig_det == 1, "R8 restart", int'(sig_det), 1);
        // R7 deassert after more than QUAL low samples
        @(negedge bit_clk);
        check(sig_det == 0, "R7 deassert", int'(sig_det), 0);
        repeat (10) @(negedge bit_clk);
        check(sig_det == 0, "R7 stays low", int'(sig_det), 0);

        // R9 power-down
        act_raw = 1;
        repeat (QUAL + 1) @(negedge bit_clk);
        check(sig_det == 1, "R6 reassert", int'(sig_det), 1);
        loop_n = 0; exp_q.delete(); mon_tag = "R4 before pd"; mon_on = 1;
        stream(8, 3, 9);
        wait_ph0();
        mon_on = 0; watch_on = 0;
        held = tx_line;
        run_en = 0;
        repeat (2) @(negedge bit_clk);
        check(rx_sym == 0, "R9 rx_sym cleared", int'(rx_sym), 0);
        check(sig_det == 0, "R9 sig_det cleared", int'(sig_det), 0);
        hclk = tx_sym_clk;
        for (int k = 0; k < 6; k++) begin
            @(negedge bit_clk);
            check(tx_line == held, "R9 line holds", int'(tx_line), int'(held));
            check(tx_sym_clk == hclk, "R9 clock stopped", int'(tx_sym_clk), int'(hclk));
        end
        run_en = 1; exp_q.delete();
        @(negedge bit_clk);
        watch_on = 1; mon_tag = "R9 resume"; mon_on = 1;
        stream(20, 5, 1);
        mon_on = 0;

        done = 1'b1;
        summary();
        $finish;
    end
endmodule